// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

This block is a synthesizable, clock-sampled stand-in for a 16-bit asynchronous static RAM whose two byte lanes can be enabled separately. It is the target memory in a memory controller's self-checking testbench. All controls are active low: chip select, write strobe, output enable, upper-lane enable and lower-lane enable. The bidirectional data bus is split into a data-in port, a data-out port and a pair of per-lane drive enables. A fast simulation clock samples the controls. The depth of the array is a parameter, so a simulation build stays small. The model keeps only the low address bits it needs, so higher addresses alias onto the stored words.

A small state machine tracks the write window. In `ST_IDLE`, the transition `GO_WRITE` is taken when chip select, write strobe and at least one lane enable are all low. In `ST_WRITE`, the machine stays put (`HOLD_WRITE`) while that window lasts, and it captures address, data and lane mask on every sample. When the window closes, the transition `COMMIT` writes the captured lanes into the array and returns to `ST_IDLE`. Read data comes straight from the array word at the current address. In the single cycle before a commit lands, data still waiting to be committed to that address is forwarded to the output.

The model also raises a one-cycle contention flag when a write window begins while the model was still driving the bus on the previous sample.

Top module: `byte_lane_sram`

## Requirements
- R1: While `sel_n` is high, both bits of `lane_drv` are 0, whatever the other controls are.
- R2: A write window is open when `sel_n`=0, `wr_n`=0 and at least one lane enable is low. The state of `rd_oe_n` has no effect on a write: data is stored, and `lane_drv` stays 00 while `wr_n` is low.
- R3: A write stores bits 7:0 only when `lo_en_n`=0 and bits 15:8 only when `hi_en_n`=0. The lane that is not enabled keeps its old content.
- R4: A read (`sel_n`=0, `wr_n`=1, `rd_oe_n`=0) sets `lane_drv[0]` exactly when `lo_en_n`=0 and `lane_drv[1]` exactly when `hi_en_n`=0. `dout` then shows the stored word at the current address.
- R5: With `sel_n`=0 and both lane enables high, `lane_drv` is 00, and a low `wr_n` stores nothing.
- R6: With `sel_n`=0, `wr_n`=1 and `rd_oe_n`=1, `lane_drv` is 00 even when lane enables are low.
- R7: The array is written on the first sample after the write window closes. It receives the address, data and lane mask of the last sample inside the window. Raising both lane enables also closes the window.
- R8: In the cycle after the window closes, a read of the same word returns the captured lanes before the commit edge.
- R9: `bus_clash` is 1 for one cycle after a sample that is inside a write window when the preceding sample had a lane driven. Otherwise it is 0.
- R10: Only address bits [log2(DEPTH)-1:0] select a word, so addresses that differ only in higher bits reach the same word.
- R11: After reset `bus_clash` is 0, and the state machine is idle, so no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 18 | Word address |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| hi_en_n | input | 1 | Upper lane (15:8) enable, active low |
| lo_en_n | input | 1 | Lower lane (7:0) enable, active low |
| din | input | 16 | Data presented by the controller |
| dout | output | 16 | Data the model would drive |
| lane_drv | output | 2 | Per-lane drive enable, bit 1 upper |
| bus_clash | output | 1 | Write started while model was driving |

## Verification
The bench builds the model with DEPTH=256, so the index is 8 bits wide. This brings aliasing within reach: addresses 0x00005, 0x10005 and 0x3FF05 all land on one word. The default 18-bit address width is kept, so the upper, ignored bits are exercised at full width. The small array leaves room for directed scenarios that hold a write window over several samples with changing data, close it by lane enables, and read in the forwarding cycle.

// File: rtl/bls_pkg.sv
package bls_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } bls_state_e;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
endpackage

// File: rtl/bls_lane_store.sv
module bls_lane_store #(
    parameter int DEPTH = 1024,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bls_wr_fsm.sv
module bls_wr_fsm
    import bls_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win,
    input  logic [AW-1:0]       idx,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [LANES-1:0]    lanes,
    output logic                commit,
    output logic                in_write,
    output logic [AW-1:0]       cap_idx,
    output logic [WORD_W-1:0]   cap_data,
    output logic [LANES-1:0]    cap_lanes
);
    bls_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: GO_WRITE, HOLD_WRITE, COMMIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win)  state_d = ST_WRITE;
            ST_WRITE: if (!win) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit   = 1'b0;
        in_write = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: begin
                in_write = 1'b1;
                commit   = !win;
            end
            default:  ;
        endcase
    end

    // capture of the latest sample inside the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_idx   <= '0;
            cap_data  <= '0;
            cap_lanes <= '0;
        end else if (win) begin
            cap_idx   <= idx;
            cap_data  <= wdata;
            cap_lanes <= lanes;
        end
    end

    p_commit_ends_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == ST_IDLE));

    p_commit_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(win));

    p_commit_has_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cap_lanes != '0));
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
    import bls_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_oe_n,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        lane_drv,
    output logic              bus_clash
);
    logic [AW-1:0]     idx;
    logic [LANES-1:0]  lane_sel;
    logic              win;
    logic              rd_on;
    logic              commit;
    logic              in_write;
    logic [AW-1:0]     cap_idx;
    logic [WORD_W-1:0] cap_data;
    logic [LANES-1:0]  cap_lanes;
    logic              drv_q;
    logic              clash_q;

    assign idx = addr[AW-1:0];

    generate
        if (AW < ADDR_W) begin : g_alias
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:AW];
        end
    endgenerate

    assign lane_sel = {!hi_en_n, !lo_en_n};
    assign win      = !sel_n && !wr_n && (lane_sel != '0);
    assign rd_on    = !sel_n && wr_n && !rd_oe_n;
    assign lane_drv = rd_on ? lane_sel : 2'b00;

    bls_wr_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .idx       (idx),
        .wdata     (din),
        .lanes     (lane_sel),
        .commit    (commit),
        .in_write  (in_write),
        .cap_idx   (cap_idx),
        .cap_data  (cap_data),
        .cap_lanes (cap_lanes)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] rd_word;
            logic              fwd;

            bls_lane_store #(.DEPTH(DEPTH), .W(LANE_W)) u_store (
                .clk   (clk),
                .we    (commit && cap_lanes[g]),
                .waddr (cap_idx),
                .wdata (cap_data[g*LANE_W +: LANE_W]),
                .raddr (idx),
                .rdata (rd_word)
            );

            assign fwd = in_write && cap_lanes[g] && (cap_idx == idx);
            assign dout[g*LANE_W +: LANE_W] = fwd ? cap_data[g*LANE_W +: LANE_W] : rd_word;
        end
    endgenerate

    // contention tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q   <= 1'b0;
            clash_q <= 1'b0;
        end else begin
            drv_q   <= |lane_drv;
            clash_q <= win && drv_q;
        end
    end

    assign bus_clash = clash_q;

    p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (lane_drv == 2'b00));

    p_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |-> (lane_drv == 2'b00));

    p_lane_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_en_n |-> !lane_drv[0]);

    p_oe_high_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && rd_oe_n) |-> (lane_drv == 2'b00));

    p_clash_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clash |-> $past(!sel_n && !wr_n));

    p_clash_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clash |=> !bus_clash);
endmodule

// File: tb/byte_lane_sram_tb_top.sv
module byte_lane_sram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] addr;
    logic        sel_n, wr_n, rd_oe_n, hi_en_n, lo_en_n;
    logic [15:0] din;
    logic [15:0] dout;
    logic [1:0]  lane_drv;
    logic        bus_clash;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_sram #(.ADDR_W(18), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
        .rd_oe_n(rd_oe_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .din(din),
        .dout(dout), .lane_drv(lane_drv), .bus_clash(bus_clash)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b1; rd_oe_n = 1'b1; hi_en_n = 1'b1; lo_en_n = 1'b1;
    endtask

    // one-sample write window, then idle (commit edge passes)
    task automatic wr(input logic [17:0] a, input logic [15:0] d,
                      input logic hn, input logic ln, input logic oen);
        @(negedge clk);
        addr = a; din = d; sel_n = 1'b0; wr_n = 1'b0;
        rd_oe_n = oen; hi_en_n = hn; lo_en_n = ln;
        #1;
        chk("R2 no drive during write", {30'd0, lane_drv}, 32'd0);
        idle();
        idle();
    endtask

    task automatic rd(input string req, input logic [17:0] a,
                      input logic hn, input logic ln,
                      input logic [1:0] exp_drv, input logic [15:0] exp_d,
                      input logic [15:0] mask);
        @(negedge clk);
        addr = a; sel_n = 1'b0; wr_n = 1'b1; rd_oe_n = 1'b0;
        hi_en_n = hn; lo_en_n = ln;
        #1;
        chk({req, " drive"}, {30'd0, lane_drv}, {30'd0, exp_drv});
        chk({req, " data"}, {16'd0, dout & mask}, {16'd0, exp_d & mask});
        idle();
    endtask

    task automatic t_reset();
        #1;
        chk("R11 clash after reset", {31'd0, bus_clash}, 32'd0);
        chk("R1 hiz after reset", {30'd0, lane_drv}, 32'd0);
    endtask

    task automatic t_deselect();
        @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b1; rd_oe_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
        #1;
        chk("R1 deselect hiz", {30'd0, lane_drv}, 32'd0);
        idle();
    endtask

    task automatic t_basic();
        wr(18'h00010, 16'hA55A, 1'b0, 1'b0, 1'b1);
        rd("R4 full read", 18'h00010, 1'b0, 1'b0, 2'b11, 16'hA55A, 16'hFFFF);
        rd("R4 low only", 18'h00010, 1'b1, 1'b0, 2'b01, 16'hA55A, 16'h00FF);
        rd("R4 high only", 18'h00010, 1'b0, 1'b1, 2'b10, 16'hA55A, 16'hFF00);
    endtask

    task automatic t_oe_ignored();
        wr(18'h00020, 16'h1234, 1'b0, 1'b0, 1'b0);
        rd("R2 write with oe low", 18'h00020, 1'b0, 1'b0, 2'b11, 16'h1234, 16'hFFFF);
    endtask

    task automatic t_lanes();
        wr(18'h00030, 16'h1111, 1'b0, 1'b0, 1'b1);
        wr(18'h00030, 16'h22CC, 1'b1, 1'b0, 1'b1);
        rd("R3 low lane write", 18'h00030, 1'b0, 1'b0, 2'b11, 16'h11CC, 16'hFFFF);
        wr(18'h00030, 16'hDD33, 1'b0, 1'b1, 1'b1);
        rd("R3 high lane write", 18'h00030, 1'b0, 1'b0, 2'b11, 16'hDDCC, 16'hFFFF);
    endtask

    task automatic t_no_lanes();
        wr(18'h00040, 16'h4444, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        addr = 18'h00040; din = 16'hBEEF; sel_n = 1'b0; wr_n = 1'b1;
        rd_oe_n = 1'b0; hi_en_n = 1'b1; lo_en_n = 1'b1;
        #1;
        chk("R5 no lanes hiz", {30'd0, lane_drv}, 32'd0);
        @(negedge clk);
        wr_n = 1'b0;
        idle();
        idle();
        rd("R5 no lanes no store", 18'h00040, 1'b0, 1'b0, 2'b11, 16'h4444, 16'hFFFF);
    endtask

    task automatic t_oe_high();
        @(negedge clk);
        addr = 18'h00010; sel_n = 1'b0; wr_n = 1'b1; rd_oe_n = 1'b1;
        hi_en_n = 1'b0; lo_en_n = 1'b0;
        #1;
        chk("R6 oe high hiz", {30'd0, lane_drv}, 32'd0);
        idle();
    endtask

    task automatic t_last_sample();
        @(negedge clk);
        addr = 18'h00050; din = 16'h0101; sel_n = 1'b0; wr_n = 1'b0;
        rd_oe_n = 1'b1; hi_en_n = 1'b0; lo_en_n = 1'b0;
        @(negedge clk);
        din = 16'h0202;
        @(negedge clk);
        din = 16'h7E7E;
        @(negedge clk);
        hi_en_n = 1'b1; lo_en_n = 1'b1; din = 16'hFFFF;
        idle();
        idle();
        rd("R7 last sample wins, closed by lane enables", 18'h00050,
           1'b0, 1'b0, 2'b11, 16'h7E7E, 16'hFFFF);
    endtask

    task automatic t_forward();
        wr(18'h00060, 16'h0000, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        addr = 18'h00060; din = 16'hC3A5; sel_n = 1'b0; wr_n = 1'b0;
        rd_oe_n = 1'b1; hi_en_n = 1'b0; lo_en_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; rd_oe_n = 1'b0;
        #1;
        chk("R8 forwarded read", {16'd0, dout}, {16'd0, 16'hC3A5});
        idle();
        rd("R8 after commit", 18'h00060, 1'b0, 1'b0, 2'b11, 16'hC3A5, 16'hFFFF);
    endtask

    task automatic t_clash();
        @(negedge clk);
        addr = 18'h00070; sel_n = 1'b0; wr_n = 1'b1; rd_oe_n = 1'b0;
        hi_en_n = 1'b0; lo_en_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b0; din = 16'h7070;
        @(negedge clk);
        #1;
        chk("R9 clash raised", {31'd0, bus_clash}, 32'd1);
        @(negedge clk);
        #1;
        chk("R9 clash one cycle", {31'd0, bus_clash}, 32'd0);
        idle();
        idle();
        wr(18'h00071, 16'h1717, 1'b0, 1'b0, 1'b1);
        #1;
        chk("R9 clean write no clash", {31'd0, bus_clash}, 32'd0);
    endtask

    task automatic t_alias();
        wr(18'h00005, 16'h5A5A, 1'b0, 1'b0, 1'b1);
        rd("R10 alias 0x10005", 18'h10005, 1'b0, 1'b0, 2'b11, 16'h5A5A, 16'hFFFF);
        wr(18'h3FF05, 16'h9696, 1'b0, 1'b0, 1'b1);
        rd("R10 alias 0x00005", 18'h00005, 1'b0, 1'b0, 2'b11, 16'h9696, 16'hFFFF);
    endtask

    initial begin
        rst_n = 1'b0;
        addr = '0; din = '0;
        sel_n = 1'b1; wr_n = 1'b1; rd_oe_n = 1'b1; hi_en_n = 1'b1; lo_en_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_deselect();
        t_basic();
        t_oe_ignored();
        t_lanes();
        t_no_lanes();
        t_oe_high();
        t_last_sample();
        t_forward();
        t_clash();
        t_alias();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule